// File: doc/BRIEF.md
# Four-Lane Framed SPI Master

This block drives two SPI links from a system clock. Each link has one serial clock and one active-low chip select. Each link also carries two data lanes, a primary and a secondary, so four devices are served in every frame. The serial clock is the system clock divided by a fixed even ratio. The default ratio of 4 turns an 80 MHz system clock into a 20 MHz serial clock.

Frames repeat on a fixed grid of 20 serial clock periods. Chip select is low for the first 17 periods and high for the last 3. At 20 MHz this gives one frame per microsecond. In each frame a 16-bit command goes out MSB-first on every MOSI lane, followed by one padding zero. At the same time a 17-bit response is shifted in on every MISO lane. The first 16 received bits become the sample word, and the 17th is thrown away.

Software-side logic writes the four next commands into holding registers with a single load strobe. Frames run whether or not a load has happened, so the last loaded commands are sent again until they are replaced. After each frame the four captured words appear together with a one-cycle completion pulse.

Top module: `quad_spi_frame_engine`

## Requirements
- R1: While `rst_i` is high (sampled at a clock edge), the outputs from the next edge onward are as follows: both chip selects high, both serial clocks low, all MOSI lanes low, `frame_done_o` low and all received words zero.
- R2: While chip select is low, the serial clock is high for 2 system cycles and low for 2, so rising edges are 4 system cycles apart. While chip select is high, the serial clock stays low.
- R3: The first frame begins on the first clock edge after reset is released. Chip select is low for 68 system cycles (17 serial periods) and high for 12 (3 serial periods), so falling edges of chip select are exactly 80 system cycles apart.
- R4: On each MOSI lane a frame carries the 16 command bits MSB-first, followed by a 17th bit of 0. The first bit is valid from the falling edge of chip select, and the lane changes only on falling serial clock edges.
- R5: MISO is sampled at each rising serial clock edge. The first bit received in a frame becomes bit 15 of the word, and the 16th becomes bit 0. The 17th bit has no effect on the word.
- R6: `frame_done_o` is a one-cycle pulse on the same edge where chip select rises. The four words on `rx_word_o` update on that edge and hold until the next pulse.
- R7: Lane n is in bits [16n+15:16n] of `cmd_i` and `rx_word_o`. Lanes 0 and 1 belong to link 0, and lanes 2 and 3 to link 1. Both links have identical clock and chip select timing, and the lanes carry independent data.
- R8: A cycle with `cmd_load_i` high stores all four `cmd_i` words into holding registers. Each frame sends the holding values present when it starts. If no load occurs, the same commands are sent again. After reset the holding values are zero.
- R9: A load that occurs while chip select is low does not alter the frame in progress. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 64 | Four command words, lane n in bits [16n+15:16n] |
| cmd_load_i | input | 1 | Store all four command words into the holding registers |
| miso_i | input | 4 | Serial data in, one bit per lane |
| sclk_o | output | 2 | Serial clock per link |
| cs_n_o | output | 2 | Active-low chip select per link |
| mosi_o | output | 4 | Serial data out, one bit per lane |
| rx_word_o | output | 64 | Four received words, lane n in bits [16n+15:16n] |
| frame_done_o | output | 1 | One-cycle pulse when the received words update |

## Verification
The hardest case to reach from the ports is a command load that lands while a frame is already shifting. The frame must keep its old word while the next one takes the new word. The bench therefore pulses the load strobe between two serial clock edges in the middle of selected frames. Other frames skip the load entirely, to show that the held command is sent again. The response patterns change the discarded 17th bit from frame to frame, and walking-one patterns sweep every bit position of every lane in both directions.

// File: rtl/qsf_pkg.sv
`timescale 1ns/1ps
package qsf_pkg;

    localparam int unsigned DEF_SYS_PER_SCLK = 4;
    localparam int unsigned DEF_SEL_SLOTS    = 17;
    localparam int unsigned DEF_FRAME_SLOTS  = 20;
    localparam int unsigned DEF_WORD_W       = 16;
    localparam int unsigned DEF_NUM_LINKS    = 2;
    localparam int unsigned DEF_LANES_LINK   = 2;

    // Events that take effect on the coming clock edge.
    typedef struct packed {
        logic load;   // frame begins: chip select falls, shifters load
        logic fall;   // serial clock falls inside the frame: shift out
        logic rise;   // serial clock rises: sample input
        logic done;   // chip select rises: publish received words
    } frame_evt_t;

endpackage

// File: rtl/qsf_timing.sv
`timescale 1ns/1ps
module qsf_timing
    import qsf_pkg::*;
#(
    parameter int unsigned SYS_PER_SCLK = DEF_SYS_PER_SCLK,
    parameter int unsigned SEL_SLOTS    = DEF_SEL_SLOTS,
    parameter int unsigned FRAME_SLOTS  = DEF_FRAME_SLOTS
) (
    input  logic       clk_i,
    input  logic       rst_i,
    output frame_evt_t evt_nx_o,
    output logic       sclk_q_o,
    output logic       cs_n_q_o
);

    localparam int unsigned PH_W   = (SYS_PER_SCLK > 1) ? $clog2(SYS_PER_SCLK) : 1;
    localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS);
    localparam int unsigned HALF   = SYS_PER_SCLK / 2;

    logic [PH_W-1:0]   ph_q, ph_nx;
    logic [SLOT_W-1:0] slot_q, slot_nx;
    logic              act_q;
    logic              sel_nx;

    always_comb begin
        if (!act_q) begin
            ph_nx   = '0;
            slot_nx = '0;
        end else if (ph_q == PH_W'(SYS_PER_SCLK - 1)) begin
            ph_nx   = '0;
            slot_nx = (slot_q == SLOT_W'(FRAME_SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
        end else begin
            ph_nx   = ph_q + PH_W'(1);
            slot_nx = slot_q;
        end
    end

    assign sel_nx = (slot_nx < SLOT_W'(SEL_SLOTS));

    always_comb begin
        evt_nx_o.load = (ph_nx == '0) && (slot_nx == '0);
        evt_nx_o.fall = (ph_nx == '0) && (slot_nx != '0) && sel_nx;
        evt_nx_o.rise = sel_nx && (ph_nx == PH_W'(HALF));
        evt_nx_o.done = (ph_nx == '0) && (slot_nx == SLOT_W'(SEL_SLOTS));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q     <= '0;
            slot_q   <= '0;
            act_q    <= 1'b0;
            sclk_q_o <= 1'b0;
            cs_n_q_o <= 1'b1;
        end else begin
            ph_q     <= ph_nx;
            slot_q   <= slot_nx;
            act_q    <= 1'b1;
            sclk_q_o <= sel_nx && (ph_nx >= PH_W'(HALF));
            cs_n_q_o <= !sel_nx;
        end
    end

endmodule

// File: rtl/qsf_cmd_hold.sv
`timescale 1ns/1ps
module qsf_cmd_hold
    import qsf_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned NUM_LANES = DEF_NUM_LINKS * DEF_LANES_LINK
) (
    input  logic                                clk_i,
    input  logic                                rst_i,
    input  logic                                load_i,
    input  logic [NUM_LANES*WORD_W-1:0]         cmd_i,
    output logic [NUM_LANES-1:0][WORD_W-1:0]    hold_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_o <= '0;
        end else if (load_i) begin
            hold_o <= cmd_i;
        end
    end

endmodule

// File: rtl/qsf_lane.sv
`timescale 1ns/1ps
module qsf_lane
    import qsf_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned SEL_SLOTS = DEF_SEL_SLOTS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  frame_evt_t        evt_i,
    input  logic [WORD_W-1:0] hold_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned SHIFT_W = SEL_SLOTS;
    localparam int unsigned PAD_W   = SHIFT_W - WORD_W;

    logic [SHIFT_W-1:0] tx_q;
    logic [SHIFT_W-1:0] rx_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tx_q   <= '0;
            rx_q   <= '0;
            word_o <= '0;
        end else begin
            if (evt_i.load) begin
                tx_q <= {hold_i, PAD_W'(0)};
            end else if (evt_i.fall) begin
                tx_q <= {tx_q[SHIFT_W-2:0], 1'b0};
            end
            if (evt_i.rise) begin
                rx_q <= {rx_q[SHIFT_W-2:0], miso_i};
            end
            if (evt_i.done) begin
                word_o <= rx_q[SHIFT_W-1 -: WORD_W];
            end
        end
    end

    assign mosi_o = tx_q[SHIFT_W-1];

endmodule

// File: rtl/quad_spi_frame_engine.sv
`timescale 1ns/1ps
module quad_spi_frame_engine
    import qsf_pkg::*;
#(
    parameter int unsigned SYS_PER_SCLK = DEF_SYS_PER_SCLK,
    parameter int unsigned SEL_SLOTS    = DEF_SEL_SLOTS,
    parameter int unsigned FRAME_SLOTS  = DEF_FRAME_SLOTS,
    parameter int unsigned WORD_W       = DEF_WORD_W,
    parameter int unsigned NUM_LINKS    = DEF_NUM_LINKS,
    parameter int unsigned LANES_LINK   = DEF_LANES_LINK
) (
    input  logic                                   clk_i,
    input  logic                                   rst_i,
    input  logic [NUM_LINKS*LANES_LINK*WORD_W-1:0] cmd_i,
    input  logic                                   cmd_load_i,
    input  logic [NUM_LINKS*LANES_LINK-1:0]        miso_i,
    output logic [NUM_LINKS-1:0]                   sclk_o,
    output logic [NUM_LINKS-1:0]                   cs_n_o,
    output logic [NUM_LINKS*LANES_LINK-1:0]        mosi_o,
    output logic [NUM_LINKS*LANES_LINK*WORD_W-1:0] rx_word_o,
    output logic                                   frame_done_o
);

    localparam int unsigned NUM_LANES = NUM_LINKS * LANES_LINK;

    frame_evt_t                          evt_nx;
    logic                                sclk_q;
    logic                                cs_n_q;
    logic [NUM_LANES-1:0][WORD_W-1:0]    hold;

    qsf_timing #(
        .SYS_PER_SCLK (SYS_PER_SCLK),
        .SEL_SLOTS    (SEL_SLOTS),
        .FRAME_SLOTS  (FRAME_SLOTS)
    ) u_timing (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .evt_nx_o (evt_nx),
        .sclk_q_o (sclk_q),
        .cs_n_q_o (cs_n_q)
    );

    qsf_cmd_hold #(
        .WORD_W    (WORD_W),
        .NUM_LANES (NUM_LANES)
    ) u_hold (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (cmd_load_i),
        .cmd_i  (cmd_i),
        .hold_o (hold)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        qsf_lane #(
            .WORD_W    (WORD_W),
            .SEL_SLOTS (SEL_SLOTS)
        ) u_lane (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .evt_i  (evt_nx),
            .hold_i (hold[g]),
            .miso_i (miso_i[g]),
            .mosi_o (mosi_o[g]),
            .word_o (rx_word_o[g*WORD_W +: WORD_W])
        );
    end

    for (genvar k = 0; k < NUM_LINKS; k++) begin : g_link
        assign sclk_o[k] = sclk_q;
        assign cs_n_o[k] = cs_n_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            frame_done_o <= 1'b0;
        end else begin
            frame_done_o <= evt_nx.done;
        end
    end

endmodule

// File: rtl/qsf_checker.sv
`timescale 1ns/1ps
module qsf_checker #(
    parameter int unsigned SYS_PER_SCLK = 4,
    parameter int unsigned SEL_SLOTS    = 17,
    parameter int unsigned FRAME_SLOTS  = 20,
    parameter int unsigned NUM_LINKS    = 2,
    parameter int unsigned NUM_LANES    = 4
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic [NUM_LINKS-1:0] sclk_o,
    input logic [NUM_LINKS-1:0] cs_n_o,
    input logic [NUM_LANES-1:0] mosi_o,
    input logic                 frame_done_o
);

    localparam int unsigned LOW_SYS  = SEL_SLOTS * SYS_PER_SCLK;
    localparam int unsigned HIGH_SYS = (FRAME_SLOTS - SEL_SLOTS) * SYS_PER_SCLK;
    localparam int unsigned HALF     = SYS_PER_SCLK / 2;
    localparam int unsigned CNT_W    = $clog2(LOW_SYS + HIGH_SYS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] low_cnt, high_cnt, hi_clk_cnt;
    logic             seen_rise;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            low_cnt    <= '0;
            high_cnt   <= '0;
            hi_clk_cnt <= '0;
            seen_rise  <= 1'b0;
        end else begin
            low_cnt    <= cs_n_o[0] ? '0 : ((low_cnt == CNT_MAX) ? low_cnt : low_cnt + 1'b1);
            high_cnt   <= !cs_n_o[0] ? '0 : ((high_cnt == CNT_MAX) ? high_cnt : high_cnt + 1'b1);
            hi_clk_cnt <= !sclk_o[0] ? '0 : ((hi_clk_cnt == CNT_MAX) ? hi_clk_cnt : hi_clk_cnt + 1'b1);
            if ($rose(cs_n_o[0])) seen_rise <= 1'b1;
        end
    end

    // R1
    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (cs_n_o == '1) && (sclk_o == '0) && (mosi_o == '0) && !frame_done_o);

    // R2
    p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n_o[0] |-> !sclk_o[0]);

    p_sclk_high_len_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sclk_o[0]) |-> (hi_clk_cnt == CNT_W'(HALF)));

    // R3
    p_cs_low_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cs_n_o[0]) |-> (low_cnt == CNT_W'(LOW_SYS)));

    p_cs_high_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(cs_n_o[0]) && seen_rise) |-> (high_cnt == CNT_W'(HIGH_SYS)));

    // R4
    p_mosi_stable_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sclk_o[0]) |-> $stable(mosi_o));

    // R6
    p_done_at_cs_rise_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_done_o |-> $rose(cs_n_o[0]));

    p_done_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_done_o |=> !frame_done_o);

    // R7
    p_links_match_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sclk_o == {NUM_LINKS{sclk_o[0]}}) && (cs_n_o == {NUM_LINKS{cs_n_o[0]}}));

endmodule

bind quad_spi_frame_engine qsf_checker #(
    .SYS_PER_SCLK (SYS_PER_SCLK),
    .SEL_SLOTS    (SEL_SLOTS),
    .FRAME_SLOTS  (FRAME_SLOTS),
    .NUM_LINKS    (NUM_LINKS),
    .NUM_LANES    (NUM_LINKS * LANES_LINK)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sclk_o       (sclk_o),
    .cs_n_o       (cs_n_o),
    .mosi_o       (mosi_o),
    .frame_done_o (frame_done_o)
);

// File: tb/sim_quad_spi_frame_engine.sv
`timescale 1ns/1ps
module sim_quad_spi_frame_engine;

    localparam int CLK_P = 10;
    localparam int NF    = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] cmd;
    logic        cmd_load;
    logic [3:0]  miso;
    logic [1:0]  sclk;
    logic [1:0]  cs_n;
    logic [3:0]  mosi;
    logic [63:0] rx_word;
    logic        frame_done;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_hold [4];
    logic [15:0] exp_cur  [4];
    logic [16:0] resp     [4];
    logic [16:0] got      [4];

    always #(CLK_P/2) clk = ~clk;

    quad_spi_frame_engine u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .cmd_i        (cmd),
        .cmd_load_i   (cmd_load),
        .miso_i       (miso),
        .sclk_o       (sclk),
        .cs_n_o       (cs_n),
        .mosi_o       (mosi),
        .rx_word_o    (rx_word),
        .frame_done_o (frame_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] cmd_val(input int f, input int l);
        logic [31:0] t;
        if (f < 16) return 16'h0001 << ((f + 3*l) % 16);
        t = f * 40503 + l * 7919 + (f << 8);
        return t[15:0];
    endfunction

    function automatic logic [16:0] resp_val(input int f, input int l);
        logic [15:0] w;
        logic [31:0] t;
        if (f < 16) begin
            w = 16'h8000 >> ((f + l) % 16);
            if (l % 2 == 1) w = ~w;
        end else begin
            t = f * 12091 + l * 4369;
            w = t[15:0];
        end
        return {w, 1'(((f ^ l) & 1))};
    endfunction

    task automatic load_cmds(input int seed);
        @(negedge clk);
        for (int l = 0; l < 4; l++) begin
            cmd[l*16 +: 16] = cmd_val(seed, l);
            exp_hold[l]     = cmd_val(seed, l);
        end
        cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    time t_fall, t_prev_fall, t_rise, t_prev_rise, t_sfall;

    task automatic run_frame(input int f, input bit mid_load);
        bit spacing_ok = 1'b1;
        bit link_ok    = 1'b1;
        for (int l = 0; l < 4; l++) begin
            exp_cur[l] = exp_hold[l];
            resp[l]    = resp_val(f, l);
        end
        @(negedge cs_n[0]);
        t_fall = $time;
        if (f > 0) chk((t_fall - t_prev_fall) == 80*CLK_P, "R3 frame period",
                       64'(t_fall - t_prev_fall), 64'(80*CLK_P));
        t_prev_fall = t_fall;
        #1;
        for (int l = 0; l < 4; l++) miso[l] = resp[l][16];
        for (int j = 0; j < 17; j++) begin
            @(posedge sclk[0]);
            t_rise = $time;
            if (j == 0) begin
                if (t_rise - t_fall != 2*CLK_P) spacing_ok = 1'b0;
            end else if (t_rise - t_prev_rise != 4*CLK_P) spacing_ok = 1'b0;
            t_prev_rise = t_rise;
            #1;
            for (int l = 0; l < 4; l++) got[l][16-j] = mosi[l];
            if (sclk != 2'b11 || cs_n != 2'b00) link_ok = 1'b0;
            @(negedge sclk[0]);
            t_sfall = $time;
            if (t_sfall - t_rise != 2*CLK_P) spacing_ok = 1'b0;
            #1;
            if (j < 16) for (int l = 0; l < 4; l++) miso[l] = resp[l][15-j];
            if (j == 5 && mid_load) load_cmds(f + 100);
        end
        chk(spacing_ok, "R2 sclk timing in frame", 64'(spacing_ok), 64'd1);
        chk(link_ok, "R7 both links selected and clocked", {62'd0, sclk}, 64'd3);
        chk((t_sfall - t_fall) == 68*CLK_P, "R3 chip select low time",
            64'(t_sfall - t_fall), 64'(68*CLK_P));
        chk(cs_n == 2'b11 && sclk == 2'b00, "R3 deselect after 17 bits", {60'd0, cs_n, sclk}, 64'hC);
        chk(frame_done == 1'b1, "R6 done with chip select rise", 64'(frame_done), 64'd1);
        for (int l = 0; l < 4; l++) begin
            chk(got[l] == {exp_cur[l], 1'b0}, mid_load ? "R9 R4 mosi word" : "R4 R8 mosi word",
                64'(got[l]), 64'({exp_cur[l], 1'b0}));
            chk(rx_word[l*16 +: 16] == resp[l][16:1], "R5 R7 received word",
                64'(rx_word[l*16 +: 16]), 64'(resp[l][16:1]));
        end
        @(posedge clk);
        #1;
        chk(frame_done == 1'b0, "R6 done single cycle", 64'(frame_done), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        cmd = '0;
        cmd_load = 1'b0;
        miso = '0;
        for (int l = 0; l < 4; l++) exp_hold[l] = '0;
        repeat (4) @(posedge clk);
        #1;
        chk(cs_n == 2'b11, "R1 chip select in reset", 64'(cs_n), 64'd3);
        chk(sclk == 2'b00 && mosi == 4'h0, "R1 sclk and mosi in reset", {58'd0, sclk, mosi}, 64'd0);
        chk(frame_done == 1'b0 && rx_word == '0, "R1 done and words in reset", rx_word, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int f = 0; f < NF; f++) begin
            bit mid  = (f % 7 == 2);
            bit skip = (f % 5 == 3);
            run_frame(f, mid);
            if (!mid && !skip) load_cmds(f + 1);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule